// File: doc/BRIEF.md
# APB Memory Completer with Wait-State and Error Injection

This block is an APB completer in front of a small word-addressed storage array. It recognises the first cycle of each transfer, and the PWRITE level at that cycle selects a store or a fetch. Writes land in the array. Reads return the stored word, or a fixed default word when the location has not been written since reset. A word-valid bit per location records which entries hold written data, so reset invalidates the whole array without clearing it.

For each transfer, a wait-count input sets how many access cycles PREADY is held low before completion. An error-inject input sets the PSLVERR level in the completing cycle. Both inputs are sampled at the setup edge. Between transfers the outputs rest at fixed values, and PREADY rests at a level chosen by a parameter. The block suits a bench or a system model that has to exercise a requester's stall and error handling against real storage.

Top module: `apb_wait_mem`

## Requirements
- R1: A transfer starts on a rising clock edge where psel=1, penable=0 and no transfer is in progress. pwrite=1 at that edge selects a store and pwrite=0 selects a fetch.
- R2: A store writes pwdata into word paddr[5:2] at the completing edge (psel, penable and pready all 1). A later fetch of that word returns the data.
- R3: A fetch of a word not written since reset returns 32'hDEAD_BEEF.
- R4: With wait count N sampled at the setup edge, pready is 0 for the N cycles that follow that edge and 1 in the cycle after them. The transfer therefore completes N+1 edges after setup.
- R5: pslverr equals the sampled error-inject value in the cycle where pready completes the transfer. A store flagged with an error still updates the array.
- R6: In the completing cycle, prdata carries the fetched word for a fetch and 0 for a store. prdata is nonzero only while pready is 1.
- R7: In the cycle after completion, pready returns to the idle level READY_IDLE (default 1) and pslverr and prdata return to 0.
- R8: With no transfer in progress, prdata=0, pslverr=0 and pready=READY_IDLE, whatever wait_cnt and err_inj do.
- R9: Asynchronous active-low reset drives prdata=0, pslverr=0 and pready=READY_IDLE, and it invalidates every word so that later fetches return the default word.
- R10: Changes to wait_cnt and err_inj after the setup edge do not affect the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Completer select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = store, 0 = fetch |
| paddr | input | ADDR_W | Byte address; bits [5:2] pick the word |
| pwdata | input | DATA_W | Store data |
| wait_cnt | input | WAIT_W | Wait cycles for the next transfer |
| err_inj | input | 1 | Error flag for the next transfer |
| prdata | output | DATA_W | Fetch data |
| pready | output | 1 | Transfer completion |
| pslverr | output | 1 | Transfer error |

## Verification
Every word is fetched before any store, which separates the default word from array contents. Stores followed by fetches across all sixteen words are then repeated with wait counts of 0, 1 and 3. This shows that the completion edge moves by exactly the programmed count, and that the data path is unaffected by stalling. Error flags follow a pattern that differs between stores and fetches, and the inject and count inputs are scrambled once the access phase begins. A wrong sampling point therefore appears as a mismatched pslverr or a shifted completion. A final reset followed by a full sweep of fetches confirms that every word is invalidated.

// File: rtl/apb_wait_mem.sv
module apb_wait_mem #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int WAIT_W = 4,
  parameter logic [DATA_W-1:0] DEFAULT_WORD = 'hDEAD_BEEF,
  parameter bit READY_IDLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [WAIT_W-1:0] wait_cnt,
  input  logic              err_inj,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int LSB   = $clog2(DATA_W / 8);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  vld;
  logic              busy, wr_q, err_q;
  logic [WAIT_W-1:0] cnt_q;

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] rd_word;
  logic              setup, done, addr_unused;

  assign idx         = paddr[LSB +: IDX_W];
  assign addr_unused = ^{paddr[ADDR_W-1:LSB+IDX_W], paddr[LSB-1:0]};
  assign rd_word     = vld[idx] ? mem[idx] : DEFAULT_WORD;
  assign setup       = psel & ~penable & ~busy;
  assign done        = busy & psel & penable & pready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      wr_q    <= 1'b0;
      err_q   <= 1'b0;
      cnt_q   <= '0;
      vld     <= '0;
      pready  <= READY_IDLE;
      pslverr <= 1'b0;
      prdata  <= '0;
    end else if (done) begin
      busy    <= 1'b0;
      pready  <= READY_IDLE;
      pslverr <= 1'b0;
      prdata  <= '0;
      if (wr_q) vld[idx] <= 1'b1;
    end else if (setup) begin
      busy  <= 1'b1;
      wr_q  <= pwrite;
      err_q <= err_inj;
      cnt_q <= wait_cnt;
      if (wait_cnt == '0) begin
        pready  <= 1'b1;
        pslverr <= err_inj;
        prdata  <= pwrite ? '0 : rd_word;
      end else begin
        pready <= 1'b0;
      end
    end else if (busy && !pready) begin
      if (cnt_q == WAIT_W'(1)) begin
        pready  <= 1'b1;
        pslverr <= err_q;
        prdata  <= wr_q ? '0 : rd_word;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk)
    if (done && wr_q) mem[idx] <= pwdata;

  a_r1_setup_starts: assert property (@(posedge clk) disable iff (!rst_n)
    setup |=> busy);
  a_r5_err_only_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    pslverr |-> pready);
  a_r6_data_only_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (prdata != '0) |-> pready);
  a_r7_release_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (pready == READY_IDLE && !pslverr && prdata == '0));
  a_r8_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pready == READY_IDLE && !pslverr && prdata == '0));
  a_r10_args_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(err_q) && $stable(wr_q)));
endmodule

// File: tb/sim_apb_wait_mem.sv
module sim_apb_wait_mem;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] DEF = 32'hDEAD_BEEF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0, err_inj = 1'b0;
  logic [31:0] paddr = '0, pwdata = '0;
  logic [3:0]  wait_cnt = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;

  int checks = 0, fails = 0;
  logic [31:0] m [16];
  bit          v [16];

  always #(CLK_PERIOD / 2) clk = ~clk;

  apb_wait_mem u0 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .wait_cnt(wait_cnt), .err_inj(err_inj),
    .prdata(prdata), .pready(pready), .pslverr(pslverr)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string rq);
    chk(prdata === 32'h0, rq, "prdata idle", prdata, 32'h0);
    chk(pslverr === 1'b0, rq, "pslverr idle", {31'h0, pslverr}, 32'h0);
    chk(pready === 1'b1, rq, "pready idle", {31'h0, pready}, 32'h1);
  endtask

  task automatic xfer(input bit wr, input int i, input logic [31:0] d,
                      input int n, input bit e);
    int c;
    logic [31:0] exp;
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr;
    paddr = 32'h0004_0000 + 32'(i * 4) + 32'(i % 4);
    pwdata = d; wait_cnt = 4'(n); err_inj = e;
    @(posedge clk);
    @(negedge clk);
    penable = 1'b1; wait_cnt = 4'hF; err_inj = ~e;
    c = 0;
    while (pready !== 1'b1 && c < 40) begin
      @(negedge clk);
      c++;
    end
    chk(c == n, "R4", "wait cycles", 32'(c), 32'(n));
    chk(pslverr === e, "R5", "pslverr at completion (R10 hold)", {31'h0, pslverr}, {31'h0, e});
    exp = wr ? 32'h0 : (v[i] ? m[i] : DEF);
    chk(prdata === exp, wr ? "R6" : (v[i] ? "R2" : "R3"), "prdata at completion", prdata, exp);
    if (wr) begin m[i] = d; v[i] = 1'b1; end
    @(posedge clk);
    #1;
    chk_idle("R7");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) v[i] = 1'b0;
    repeat (3) @(negedge clk);
    chk_idle("R9");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_idle("R8");

    // R3: nothing written yet
    for (int i = 0; i < 16; i++) xfer(1'b0, i, 32'h0, 0, 1'b0);

    // R1 R2 R4 R5 R6: sweep over wait counts
    foreach (m[k]) begin end
    for (int s = 0; s < 3; s++) begin
      int n;
      n = (s == 0) ? 0 : (s == 1) ? 1 : 3;
      for (int i = 0; i < 16; i++)
        xfer(1'b1, i, 32'hA500_0000 ^ (32'(i) * 32'h0101_0101) ^ (32'(n) << 20),
             n, (i % 3) == 0);
      for (int i = 0; i < 16; i++)
        xfer(1'b0, i, 32'h0, n, (i % 4) == 1);
    end

    // R8: idle while control inputs wiggle
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
    for (int k = 0; k < 6; k++) begin
      wait_cnt = 4'(k); err_inj = k[0];
      @(negedge clk);
      chk_idle("R8");
    end

    // R9: reset invalidates all words
    rst_n = 1'b0;
    #1;
    chk_idle("R9");
    for (int i = 0; i < 16; i++) v[i] = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) begin
      xfer(1'b0, i, 32'h0, i % 2, 1'b0);
      chk(1'b1, "R9", "post-reset fetch done", 32'h0, 32'h0);
    end

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule